// File: doc/BRIEF.md
# Sector Lockout and Restricted Mode Unit

This block checks memory protection. It sits between processor control and the memory array. Memory is split into 512-word sectors. A mask register holds one bit per sector, and a bit of 0 marks that sector as protected. A 6-bit relocation register gives the sector that an instruction uses when its sector flag is clear, so a program can be given its own sector zero instead of the true one. A restricted-mode flag is set by a dedicated strobe and is cleared only when an interrupt is taken.

While the unit is in restricted mode it checks three things: every memory write against the mask, every decoded instruction against a list of privileged operation codes, and every indirect-address cycle against a depth limit. Any violation raises `abort_o` combinationally in the same cycle as the offending request. A blocked write therefore never reaches the memory write enable. An interrupt request is then latched and held until an interrupt is taken. In normal mode nothing is checked and all writes pass.

Top module: `sector_guard`

## Requirements
- R1: After reset, `restrict_o` and `irq_req_o` are 0. The relocation register is 0. Every mask bit is 1, so even in restricted mode every sector accepts writes.
- R2: A pulse on `mask_we_i` loads `mask_data_i` into mask bits [16k+15:16k], where k = `mask_idx_i`. Mask bit s covers sector s, and s = `wr_addr_i[14:9]`.
- R3: In restricted mode, a write (`wr_req_i`) to a sector whose mask bit is 0 drives `mem_we_o` low and `abort_o` high in the same cycle. A write to a sector whose mask bit is 1 drives `mem_we_o` high and `abort_o` low.
- R4: In restricted mode, `op_valid_i` with `op_code_i` 1 through 8 raises `abort_o` in that cycle. These codes stand for control pulse, skip on status, word output, mask set, word input, key output, halt and interrupt inhibit. Codes 0 and 9 through 15 do not abort.
- R5: In restricted mode, the first eight `ind_step_i` cycles after an `op_valid_i` do not abort, and the ninth and later ones do. An `ind_step_i` in the same cycle as `op_valid_i` counts as the first step of the new instruction.
- R6: In normal mode, `abort_o` stays 0 and `mem_we_o` equals `wr_req_i`.
- R7: `enter_restrict_i` sets `restrict_o` on the next cycle. `irq_taken_i` clears it on the next cycle, and if both arrive together the clear wins.
- R8: `irq_req_o` becomes 1 in the cycle after any abort. It stays 1 until a cycle with `irq_taken_i` and no abort, after which it reads 0.
- R9: `sect_o` equals `pc_sect_i` when `sect_flag_i` is 1. When `sect_flag_i` is 0 it equals the relocation register, which a `reloc_we_i` pulse loads from `reloc_data_i`.
- R10: In restricted mode, `mask_we_i` and `reloc_we_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mask_we_i | input | 1 | Load one mask word |
| mask_idx_i | input | 2 | Mask word index |
| mask_data_i | input | 16 | Mask word data |
| reloc_we_i | input | 1 | Load relocation register |
| reloc_data_i | input | 6 | Relocation sector |
| enter_restrict_i | input | 1 | Enter restricted mode |
| irq_taken_i | input | 1 | An interrupt is being taken |
| wr_req_i | input | 1 | Memory write request |
| wr_addr_i | input | 15 | Memory write word address |
| op_valid_i | input | 1 | New instruction decoded |
| op_code_i | input | 4 | Operation class of the decoded instruction |
| ind_step_i | input | 1 | Indirect-address cycle |
| sect_flag_i | input | 1 | Instruction sector flag |
| pc_sect_i | input | 6 | Sector of the program counter |
| mem_we_o | output | 1 | Write enable to memory |
| abort_o | output | 1 | Violation in this cycle |
| irq_req_o | output | 1 | Latched protection interrupt request |
| restrict_o | output | 1 | Restricted mode active |
| sect_o | output | 6 | Sector selected for the operand address |

## Verification
On every cycle the assertions check the following. A write to a protected sector in restricted mode is blocked and flagged. In normal mode no abort occurs and writes pass through. Privileged codes abort in restricted mode. Every abort is followed by a pending interrupt request. The mode flag follows the enter and interrupt strobes. Other behaviour shows only in the bench's scenarios: which mask bit belongs to which sector after a word load, the exact indirect step at which the depth limit trips, the relocation path, and the fact that register loads are ignored in restricted mode. The bench sweeps every sector, every operation code and every relocation value.

// File: rtl/sector_guard_pkg.sv
package sector_guard_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_PLAIN     = 4'd0,
    OP_CTL_PULSE = 4'd1,
    OP_SKIP_STAT = 4'd2,
    OP_OUT_WORD  = 4'd3,
    OP_SET_MASK  = 4'd4,
    OP_IN_WORD   = 4'd5,
    OP_KEY_OUT   = 4'd6,
    OP_HALT      = 4'd7,
    OP_IRQ_INH   = 4'd8
  } op_kind_e;

  function automatic logic op_is_priv(input logic [OP_W-1:0] code);
    return (code >= OP_CTL_PULSE) && (code <= OP_IRQ_INH);
  endfunction
endpackage

// File: rtl/guard_regs.sv
module guard_regs #(
  parameter int N_WORD = 4,
  parameter int WORD_W = 16,
  parameter int SECT_W = 6,
  localparam int IDX_W = (N_WORD > 1) ? $clog2(N_WORD) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mask_we_i,
  input  logic [IDX_W-1:0]         mask_idx_i,
  input  logic [WORD_W-1:0]        mask_data_i,
  input  logic                     reloc_we_i,
  input  logic [SECT_W-1:0]        reloc_data_i,
  output logic [N_WORD*WORD_W-1:0] mask_o,
  output logic [SECT_W-1:0]        reloc_o
);
  for (genvar k = 0; k < N_WORD; k++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  word_q <= '1;
      else if (mask_we_i && mask_idx_i == IDX_W'(k)) word_q <= mask_data_i;
    end
    assign mask_o[k*WORD_W +: WORD_W] = word_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         reloc_o <= '0;
    else if (reloc_we_i) reloc_o <= reloc_data_i;
  end
endmodule

// File: rtl/ind_depth.sv
module ind_depth #(
  parameter int MAX_IND = 8,
  localparam int CNT_W = $clog2(MAX_IND + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic op_valid_i,
  input  logic ind_step_i,
  output logic over_o
);
  logic [CNT_W-1:0] cnt_q, cur;

  assign cur    = op_valid_i ? '0 : cnt_q;
  assign over_o = ind_step_i && (cur >= CNT_W'(MAX_IND));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (ind_step_i && cur < CNT_W'(MAX_IND)) cnt_q <= cur + 1'b1;
    else cnt_q <= cur;
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sector_guard_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int OFFS_W  = 9,
  parameter int WORD_W  = 16,
  parameter int MAX_IND = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  mask_we_i,
  input  logic [$clog2((1<<(ADDR_W-OFFS_W))/WORD_W)-1:0] mask_idx_i,
  input  logic [WORD_W-1:0]                     mask_data_i,
  input  logic                                  reloc_we_i,
  input  logic [ADDR_W-OFFS_W-1:0]              reloc_data_i,
  input  logic                                  enter_restrict_i,
  input  logic                                  irq_taken_i,
  input  logic                                  wr_req_i,
  input  logic [ADDR_W-1:0]                     wr_addr_i,
  input  logic                                  op_valid_i,
  input  logic [OP_W-1:0]                       op_code_i,
  input  logic                                  ind_step_i,
  input  logic                                  sect_flag_i,
  input  logic [ADDR_W-OFFS_W-1:0]              pc_sect_i,
  output logic                                  mem_we_o,
  output logic                                  abort_o,
  output logic                                  irq_req_o,
  output logic                                  restrict_o,
  output logic [ADDR_W-OFFS_W-1:0]              sect_o
);
  localparam int SECT_W = ADDR_W - OFFS_W;
  localparam int N_SECT = 1 << SECT_W;
  localparam int N_WORD = N_SECT / WORD_W;

  logic [N_SECT-1:0] mask_w;
  logic [SECT_W-1:0] reloc_w;
  logic              deep_w;
  logic              wr_bad, op_bad, ind_bad;

  guard_regs #(.N_WORD(N_WORD), .WORD_W(WORD_W), .SECT_W(SECT_W)) i_regs (
    .clk_i, .rst_ni,
    .mask_we_i   (mask_we_i && !restrict_o),
    .mask_idx_i,
    .mask_data_i,
    .reloc_we_i  (reloc_we_i && !restrict_o),
    .reloc_data_i,
    .mask_o      (mask_w),
    .reloc_o     (reloc_w)
  );

  ind_depth #(.MAX_IND(MAX_IND)) i_depth (
    .clk_i, .rst_ni, .op_valid_i, .ind_step_i, .over_o(deep_w)
  );

  assign wr_bad  = restrict_o && wr_req_i && !mask_w[wr_addr_i[ADDR_W-1:OFFS_W]];
  assign op_bad  = restrict_o && op_valid_i && op_is_priv(op_code_i);
  assign ind_bad = restrict_o && deep_w;

  assign abort_o  = wr_bad || op_bad || ind_bad;
  assign mem_we_o = wr_req_i && !wr_bad;
  assign sect_o   = sect_flag_i ? pc_sect_i : reloc_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               restrict_o <= 1'b0;
    else if (irq_taken_i)      restrict_o <= 1'b0;
    else if (enter_restrict_i) restrict_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          irq_req_o <= 1'b0;
    else if (abort_o)     irq_req_o <= 1'b1;
    else if (irq_taken_i) irq_req_o <= 1'b0;
  end
endmodule

// File: rtl/sector_guard_chk.sv
module sector_guard_chk #(
  parameter int ADDR_W = 15,
  parameter int OFFS_W = 9
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_req_i,
  input logic [ADDR_W-1:0]             wr_addr_i,
  input logic                          op_valid_i,
  input logic [3:0]                    op_code_i,
  input logic                          enter_restrict_i,
  input logic                          irq_taken_i,
  input logic                          mem_we_o,
  input logic                          abort_o,
  input logic                          irq_req_o,
  input logic                          restrict_o,
  input logic [(1<<(ADDR_W-OFFS_W))-1:0] mask_w
);
  // R3
  prot_write_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restrict_o && wr_req_i && !mask_w[wr_addr_i[ADDR_W-1:OFFS_W]] |-> !mem_we_o && abort_o);
  // R6
  normal_no_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restrict_o |-> !abort_o && (mem_we_o == wr_req_i));
  // R4
  priv_op_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restrict_o && op_valid_i && op_code_i >= 4'd1 && op_code_i <= 4'd8 |-> abort_o);
  // R8
  abort_raises_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> irq_req_o);
  // R7
  irq_leaves_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_taken_i |=> !restrict_o);
  // R7
  enter_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_restrict_i && !irq_taken_i |=> restrict_o);
endmodule

bind sector_guard sector_guard_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) i_chk (
  .clk_i, .rst_ni, .wr_req_i, .wr_addr_i, .op_valid_i, .op_code_i,
  .enter_restrict_i, .irq_taken_i, .mem_we_o, .abort_o, .irq_req_o,
  .restrict_o, .mask_w
);

// File: tb/test_sector_guard.sv
module test_sector_guard;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mask_we_i = 0, reloc_we_i = 0, enter_restrict_i = 0, irq_taken_i = 0;
  logic wr_req_i = 0, op_valid_i = 0, ind_step_i = 0, sect_flag_i = 0;
  logic [1:0]  mask_idx_i = 0;
  logic [15:0] mask_data_i = 0;
  logic [5:0]  reloc_data_i = 0, pc_sect_i = 0;
  logic [14:0] wr_addr_i = 0;
  logic [3:0]  op_code_i = 0;
  logic mem_we_o, abort_o, irq_req_o, restrict_o;
  logic [5:0] sect_o;
  int nchk = 0, nerr = 0;

  sector_guard i_sector_guard (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  function automatic logic [15:0] pat(input int k, input logic [15:0] base);
    return base ^ 16'(k * 16'h0F0F);
  endfunction

  task automatic sweep_writes(input string req, input logic [15:0] base, input bit all_open);
    for (int s = 0; s < 64; s++) begin
      logic ok;
      ok = all_open ? 1'b1 : pat(s / 16, base)[s % 16];
      wr_req_i = 1; wr_addr_i = {6'(s), 9'((s * 37) % 512)};
      #2;
      check({req, " mem_we"}, 16'(mem_we_o), 16'(ok));
      check({req, " abort"}, 16'(abort_o), 16'(!ok));
      tick();
    end
    wr_req_i = 0;
  endtask

  task automatic load_mask(input logic [15:0] base);
    for (int k = 0; k < 4; k++) begin
      mask_we_i = 1; mask_idx_i = 2'(k); mask_data_i = pat(k, base);
      tick();
    end
    mask_we_i = 0;
  endtask

  task automatic take_irq();
    irq_taken_i = 1; tick(); irq_taken_i = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    check("R1 restrict", 16'(restrict_o), 16'd0);
    check("R1 irq_req", 16'(irq_req_o), 16'd0);
    sect_flag_i = 0; #2;
    check("R1 reloc", 16'(sect_o), 16'd0);
    enter_restrict_i = 1; tick(); enter_restrict_i = 0;
    check("R7 enter", 16'(restrict_o), 16'd1);
    sweep_writes("R1 open", 16'h0, 1'b1);
    check("R1 no irq", 16'(irq_req_o), 16'd0);
    take_irq();
    check("R7 irq exit", 16'(restrict_o), 16'd0);

    // R2 mask load, R6 normal mode passes all
    load_mask(16'hA5C3);
    sweep_writes("R6 normal", 16'h0, 1'b1);
    for (int op = 0; op < 16; op++) begin
      op_valid_i = 1; op_code_i = 4'(op); #2;
      check("R6 op", 16'(abort_o), 16'd0);
      tick();
    end
    op_valid_i = 0;
    for (int i = 1; i <= 10; i++) begin
      ind_step_i = 1; #2;
      check("R6 ind", 16'(abort_o), 16'd0);
      tick();
    end
    ind_step_i = 0;
    check("R6 no irq", 16'(irq_req_o), 16'd0);

    // R3 restricted write sweep against R2 pattern
    enter_restrict_i = 1; tick(); enter_restrict_i = 0;
    sweep_writes("R3 R2 sect", 16'hA5C3, 1'b0);
    check("R8 irq set", 16'(irq_req_o), 16'd1);
    tick();
    check("R8 irq held", 16'(irq_req_o), 16'd1);

    // R10 loads ignored in restricted mode
    load_mask(16'hFFFF);
    reloc_we_i = 1; reloc_data_i = 6'd33; tick(); reloc_we_i = 0;
    sect_flag_i = 0; #2;
    check("R10 reloc", 16'(sect_o), 16'd0);
    sweep_writes("R10 mask", 16'hA5C3, 1'b0);

    // R4 privileged codes
    for (int op = 0; op < 16; op++) begin
      op_valid_i = 1; op_code_i = 4'(op); #2;
      check("R4 op", 16'(abort_o), 16'(op >= 1 && op <= 8));
      tick();
    end
    op_valid_i = 0;

    // R5 indirect depth
    op_valid_i = 1; op_code_i = 4'd0; tick(); op_valid_i = 0;
    for (int i = 1; i <= 11; i++) begin
      ind_step_i = 1; #2;
      check("R5 depth", 16'(abort_o), 16'(i > 8));
      tick();
    end
    op_valid_i = 1; #2;
    check("R5 restart", 16'(abort_o), 16'd0);
    tick(); op_valid_i = 0;
    for (int i = 2; i <= 9; i++) begin
      #2;
      check("R5 chain", 16'(abort_o), 16'(i > 8));
      tick();
    end
    ind_step_i = 0;

    // R8 clear, R7 clear wins over enter
    irq_taken_i = 1; enter_restrict_i = 1; tick();
    irq_taken_i = 0; enter_restrict_i = 0;
    check("R7 clear wins", 16'(restrict_o), 16'd0);
    check("R8 irq clear", 16'(irq_req_o), 16'd0);

    // R9 relocation and program sector
    for (int s = 0; s < 64; s++) begin
      reloc_we_i = 1; reloc_data_i = 6'(s); tick(); reloc_we_i = 0;
      pc_sect_i = 6'(63 - s);
      sect_flag_i = 0; #2;
      check("R9 reloc", 16'(sect_o), 16'(s));
      sect_flag_i = 1; #2;
      check("R9 pc", 16'(sect_o), 16'(63 - s));
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    nerr++; nchk++;
    $display("FAIL watchdog act=1 exp=0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule